// File: doc/BRIEF.md
# Synchronous Burst Pseudo-Static RAM Host Controller

This block sits on the host side of a 1M x 16 pseudo-static RAM that has been set up for synchronous operation with continuous bursts. A requester gives it a start word address, a direction and a word count. The controller then runs the memory's clocked control bus: it pulses the address-valid strobe, holds chip enable low, and moves one 16-bit word per clock whenever the memory's wait line is inactive. Write data and per-word byte enables come from a streaming source that the controller acknowledges once per consumed word. Read words come back on a registered output with a valid flag.

The memory needs a refresh window, so one chip-enable-low period may not last longer than a bounded number of clocks. The controller counts those clocks. When the limit is reached it closes the burst and keeps chip enable high for a minimum gap. It then opens a new burst at the next word address with the words that remain. The requester sees only one completion pulse. The memory can stall the transfer at three points: during the initial latency, at 128-word row crossings, and during refresh collisions. In each case the controller holds its address pointer and its word count until the stall clears. It also refuses to move data before the programmed latency has elapsed, whatever the wait line shows.

Top module: `psram_burst_ctrl`

## Requirements
- R1: After reset and while idle, the memory bus is quiet: chip enable, address strobe, output enable and write enable are all high (inactive), `req_ready` is 1, and `rd_valid` and `done` are 0.
- R2: Each burst starts with exactly one clock in which `mem_adv_n` is 0, with `mem_ce_n` 0 and the start address on `mem_addr`. In that clock `mem_we_n` is 0 for a write request and 1 for a read request.
- R3: No word moves in the first LATENCY-1 clocks after the address clock, even if `mem_wait_n` is high. With the default LATENCY of 3 and no stall, the first read word appears on `rd_data` with `rd_valid` exactly LATENCY+1 clocks after the address clock.
- R4: When `mem_wait_n` is 0 (active) during the data phase, no word moves: there is no `wr_pull`, no read capture, and neither the address pointer nor the remaining count changes. This covers the initial delay, row-crossing stalls and long refresh-collision stalls.
- R5: While `mem_wait_n` is 1 after the latency, one word moves on each clock. Read words come out on `rd_data` in ascending address order.
- R6: In the write data phase, `mem_dq_out` carries `wr_data`, `mem_lb_n` is the inverse of `wr_be[0]` (low byte, bits 7:0), `mem_ub_n` is the inverse of `wr_be[1]` (high byte, bits 15:8), and `wr_pull` marks each consumed word.
- R7: In the read data phase, `mem_oe_n` is 0, `mem_we_n` is 1, both byte lanes are enabled, and `mem_dq_oe` is 0.
- R8: `mem_ce_n` never stays low for more than CE_LIMIT consecutive clocks. When the limit is reached with words left, the burst closes and a new burst opens at the next word address, so the request still transfers every word exactly once.
- R9: Once `mem_ce_n` rises, it stays high for at least CE_GAP clocks.
- R10: `done` pulses for one clock after the final word, in the same clock as the last `rd_valid` of a read. `req_ready` is 1 only while no burst is in progress.
- R11: A request with a word count of 0 is ignored: the bus stays quiet and no `done` follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller and memory bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller idle, request taken this clock |
| req_write | input | 1 | 1 = write burst, 0 = read burst |
| req_addr | input | 20 | Start word address |
| req_len | input | 16 | Number of words, 0 ignored |
| wr_data | input | 16 | Current write word from the stream |
| wr_be | input | 2 | Byte enables for the current write word |
| wr_pull | output | 1 | Current write word consumed this clock |
| rd_data | output | 16 | Read word |
| rd_valid | output | 1 | `rd_data` valid |
| done | output | 1 | Request complete pulse |
| mem_ce_n | output | 1 | Memory chip enable, active low |
| mem_adv_n | output | 1 | Address-valid strobe, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_lb_n | output | 1 | Low byte enable, active low |
| mem_ub_n | output | 1 | High byte enable, active low |
| mem_addr | output | 20 | Address bus, driven in the address clock |
| mem_dq_out | output | 16 | Write data toward the memory |
| mem_dq_oe | output | 1 | Data bus drive enable |
| mem_dq_in | input | 16 | Read data from the memory |
| mem_wait_n | input | 1 | Memory wait, active low |

## Verification
The hardest case to reach from the ports is a row-crossing stall inside a burst that is also cut short by the chip-enable limit. Only then does the restart address depend on words counted across a stall. The bench's memory model raises wait for two clocks after the last word of each 128-word row. It can also add extra wait clocks at each burst start to imitate refresh collisions. The stimulus table places bursts across row ends and makes them longer than a reduced CE_LIMIT. A second model mode releases wait early to show that the latency count is kept on its own.

// File: rtl/psram_pkg.sv
package psram_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_ADDR = 2'd1,
        ST_XFER = 2'd2,
        ST_GAP  = 2'd3
    } bus_state_t;

endpackage

// File: rtl/psram_ce_guard.sv
module psram_ce_guard #(
    parameter int LIMIT = 800
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ce_low,
    output logic at_limit
);
    localparam int CNT_W = $clog2(LIMIT + 1);

    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = ce_low ? cnt_q + CNT_W'(1) : '0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    // current clock is the LIMIT-th consecutive low clock
    assign at_limit = ce_low && (cnt_q == CNT_W'(LIMIT - 1));

    a_r8_ce_cap: assert property (@(posedge clk) disable iff (!rst_n)
        ce_low |-> (cnt_q < CNT_W'(LIMIT)));

    a_r8_cnt_clear: assert property (@(posedge clk) disable iff (!rst_n)
        !ce_low |=> (cnt_q == '0));
endmodule

// File: rtl/psram_rd_stage.sv
module psram_rd_stage #(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cap,
    input  logic [DATA_W-1:0] din,
    output logic [DATA_W-1:0] dout,
    output logic              dvalid
);
    typedef struct packed {
        logic [DATA_W-1:0] data;
        logic              vld;
    } rd_t;

    rd_t rd_d, rd_q;

    always_comb begin
        rd_d      = rd_q;
        rd_d.vld  = cap;
        if (cap) rd_d.data = din;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) rd_q <= '0;
        else        rd_q <= rd_d;
    end

    assign dout   = rd_q.data;
    assign dvalid = rd_q.vld;
endmodule

// File: rtl/psram_burst_ctrl.sv
module psram_burst_ctrl
    import psram_pkg::*;
#(
    parameter int ADDR_W   = 20,
    parameter int DATA_W   = 16,
    parameter int LEN_W    = 16,
    parameter int LATENCY  = 3,
    parameter int CE_LIMIT = 800,
    parameter int CE_GAP   = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [LEN_W-1:0]  req_len,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [1:0]        wr_be,
    output logic              wr_pull,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_valid,
    output logic              done,
    output logic              mem_ce_n,
    output logic              mem_adv_n,
    output logic              mem_oe_n,
    output logic              mem_we_n,
    output logic              mem_lb_n,
    output logic              mem_ub_n,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_dq_out,
    output logic              mem_dq_oe,
    input  logic [DATA_W-1:0] mem_dq_in,
    input  logic              mem_wait_n
);
    localparam int LAT_W = $clog2(LATENCY + 1);
    localparam int GAP_W = $clog2(CE_GAP + 1);

    typedef struct packed {
        bus_state_t        st;
        logic [ADDR_W-1:0] addr;
        logic [LEN_W-1:0]  rem;
        logic              wr;
        logic [LAT_W-1:0]  lat;
        logic [GAP_W-1:0]  gap;
        logic              done;
    } ctl_t;

    ctl_t cur_d, cur_q;
    logic go;
    logic ce_low;
    logic ce_at_limit;

    assign ce_low = (cur_q.st == ST_ADDR) || (cur_q.st == ST_XFER);

    psram_ce_guard #(.LIMIT(CE_LIMIT)) u_guard (
        .clk      (clk),
        .rst_n    (rst_n),
        .ce_low   (ce_low),
        .at_limit (ce_at_limit)
    );

    always_comb begin
        cur_d      = cur_q;
        cur_d.done = 1'b0;
        go         = 1'b0;
        unique case (cur_q.st)
            ST_IDLE: begin
                if (req_valid && (req_len != '0)) begin
                    cur_d.st   = ST_ADDR;
                    cur_d.addr = req_addr;
                    cur_d.rem  = req_len;
                    cur_d.wr   = req_write;
                end
            end
            ST_ADDR: begin
                cur_d.lat = LAT_W'(LATENCY - 1);
                cur_d.gap = GAP_W'(CE_GAP - 1);
                cur_d.st  = ce_at_limit ? ST_GAP : ST_XFER;
            end
            ST_XFER: begin
                if (cur_q.lat != '0) cur_d.lat = cur_q.lat - LAT_W'(1);
                go = (cur_q.lat == '0) && mem_wait_n;
                if (go) begin
                    cur_d.addr = cur_q.addr + ADDR_W'(1);
                    cur_d.rem  = cur_q.rem - LEN_W'(1);
                    if (cur_q.rem == LEN_W'(1)) cur_d.done = 1'b1;
                end
                if ((go && (cur_q.rem == LEN_W'(1))) || ce_at_limit) begin
                    cur_d.st  = ST_GAP;
                    cur_d.gap = GAP_W'(CE_GAP - 1);
                end
            end
            ST_GAP: begin
                if (cur_q.gap != '0) cur_d.gap = cur_q.gap - GAP_W'(1);
                else                 cur_d.st  = (cur_q.rem != '0) ? ST_ADDR : ST_IDLE;
            end
            default: cur_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_q    <= '0;
            cur_q.st <= ST_IDLE;
        end else begin
            cur_q <= cur_d;
        end
    end

    psram_rd_stage #(.DATA_W(DATA_W)) u_rd (
        .clk    (clk),
        .rst_n  (rst_n),
        .cap    (go && !cur_q.wr),
        .din    (mem_dq_in),
        .dout   (rd_data),
        .dvalid (rd_valid)
    );

    logic wr_phase;
    assign wr_phase = (cur_q.st == ST_XFER) && cur_q.wr;

    assign req_ready  = (cur_q.st == ST_IDLE);
    assign wr_pull    = go && cur_q.wr;
    assign done       = cur_q.done;
    assign mem_ce_n   = !ce_low;
    assign mem_adv_n  = (cur_q.st != ST_ADDR);
    assign mem_we_n   = !(ce_low && cur_q.wr);
    assign mem_oe_n   = !((cur_q.st == ST_XFER) && !cur_q.wr);
    assign mem_addr   = (cur_q.st == ST_ADDR) ? cur_q.addr : '0;
    assign mem_dq_oe  = wr_phase;
    assign mem_dq_out = wr_phase ? wr_data : '0;
    assign mem_lb_n   = wr_phase ? !wr_be[0] : !ce_low;
    assign mem_ub_n   = wr_phase ? !wr_be[1] : !ce_low;

    a_r2_adv_single: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_adv_n |=> mem_adv_n);

    a_r4_hold_on_wait: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_q.st == ST_XFER && !mem_wait_n) |=> ($stable(cur_q.addr) && $stable(cur_q.rem)));

    a_r7_read_lanes: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_oe_n |-> (mem_we_n && !mem_dq_oe && !mem_lb_n && !mem_ub_n));

    a_r10_ready_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (mem_ce_n && !wr_pull));

    generate
        if (CE_GAP >= 2) begin : g_gap_chk
            a_r9_ce_gap: assert property (@(posedge clk) disable iff (!rst_n)
                $rose(mem_ce_n) |=> mem_ce_n);
        end
    endgenerate
endmodule

// File: tb/tb_psram_burst_ctrl.sv
module tb_psram_burst_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam int LAT        = 3;
    localparam int CE_LIM     = 24;
    localparam int GAP        = 2;
    localparam int ROW_STALL  = 2;
    localparam int NVEC       = 6;

    // {addr[19:0], len[15:0], inject[3:0], exp_adv[3:0], pad[3:0], seed[15:0]}
    localparam logic [63:0] VEC [NVEC] = '{
        {20'h00010, 16'd4,  4'd0, 4'd1, 4'd0, 16'h1357},
        {20'h0007C, 16'd8,  4'd0, 4'd1, 4'd0, 16'h2468},
        {20'h000F0, 16'd16, 4'd2, 4'd1, 4'd0, 16'h3A3A},
        {20'h00020, 16'd40, 4'd0, 4'd2, 4'd0, 16'h4C01},
        {20'h00150, 16'd1,  4'd5, 4'd1, 4'd0, 16'h5E5E},
        {20'h001F0, 16'd20, 4'd0, 4'd2, 4'd0, 16'h6070}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #(CLK_PERIOD/2) clk = ~clk;

    logic        req_valid = 1'b0, req_write = 1'b0;
    logic [19:0] req_addr = '0;
    logic [15:0] req_len = '0;
    logic [15:0] wr_data;
    logic [1:0]  wr_be = 2'b11;
    logic        req_ready, wr_pull, rd_valid, done;
    logic [15:0] rd_data;
    logic        ce_n, adv_n, oe_n, we_n, lb_n, ub_n, dq_oe;
    logic [19:0] m_addr;
    logic [15:0] dq_out, dq_in;
    logic        m_wait_n;

    psram_burst_ctrl #(
        .LATENCY(LAT), .CE_LIMIT(CE_LIM), .CE_GAP(GAP)
    ) dut (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
        .req_addr(req_addr), .req_len(req_len),
        .wr_data(wr_data), .wr_be(wr_be), .wr_pull(wr_pull),
        .rd_data(rd_data), .rd_valid(rd_valid), .done(done),
        .mem_ce_n(ce_n), .mem_adv_n(adv_n), .mem_oe_n(oe_n), .mem_we_n(we_n),
        .mem_lb_n(lb_n), .mem_ub_n(ub_n), .mem_addr(m_addr),
        .mem_dq_out(dq_out), .mem_dq_oe(dq_oe), .mem_dq_in(dq_in),
        .mem_wait_n(m_wait_n)
    );

    int checks = 0;
    int fails  = 0;

    // ---------------- memory model ----------------
    logic [15:0] mem_m [512];
    logic [15:0] shadow [512];
    logic [8:0]  bptr;
    int          stall, since;
    int          inject = 0;
    logic        early = 1'b0;
    logic        m_xfer;

    assign m_wait_n = ce_n ? 1'b1 : (!adv_n ? 1'b0 : (stall == 0));
    assign m_xfer   = !ce_n && adv_n && m_wait_n && (since >= LAT);
    assign dq_in    = mem_m[bptr];

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 512; i++) mem_m[i] <= 16'(i * 7 + 3);
            bptr <= '0; stall <= 0; since <= 0;
        end else if (!ce_n && !adv_n) begin
            bptr  <= m_addr[8:0];
            stall <= early ? inject : (LAT - 1 + inject);
            since <= 1;
        end else if (!ce_n) begin
            if (since < 1000) since <= since + 1;
            if (m_xfer) begin
                if (!we_n && !lb_n) mem_m[bptr][7:0]  <= dq_out[7:0];
                if (!we_n && !ub_n) mem_m[bptr][15:8] <= dq_out[15:8];
                bptr <= bptr + 9'd1;
                if (bptr[6:0] == 7'h7F) stall <= ROW_STALL;
            end else if (stall != 0) begin
                stall <= stall - 1;
            end
        end
    end

    // ---------------- write stream ----------------
    logic        mon_clr = 1'b0;
    logic [15:0] op_seed = '0;
    int          wr_idx;

    function automatic logic [15:0] word_of(input logic [15:0] s, input int i);
        return s + 16'(i) * 16'h0103;
    endfunction

    assign wr_data = word_of(op_seed, wr_idx);

    always @(posedge clk) begin
        if (!rst_n || mon_clr) wr_idx <= 0;
        else if (wr_pull)      wr_idx <= wr_idx + 1;
    end

    // ---------------- monitors (sampled on falling edge) ----------------
    logic [15:0] rbuf [64];
    int rd_cnt, adv_cnt, done_cnt, run, max_run, hrun, min_gap, cyc;
    int adv_cyc, first_rd_cyc;
    logic seen_low, got_adv, got_rd, prev_adv;
    logic bad_adv, bad_rd, bad_wait, bad_ready;

    always @(negedge clk) begin
        cyc <= cyc + 1;
        if (mon_clr || !rst_n) begin
            rd_cnt <= 0; adv_cnt <= 0; done_cnt <= 0; run <= 0; max_run <= 0;
            hrun <= 0; min_gap <= 999; seen_low <= 1'b0; got_adv <= 1'b0;
            got_rd <= 1'b0; prev_adv <= 1'b0; bad_adv <= 1'b0; bad_rd <= 1'b0;
            bad_wait <= 1'b0; bad_ready <= 1'b0; adv_cyc <= 0; first_rd_cyc <= 0;
            if (!rst_n) cyc <= 0;
        end else begin
            if (rd_valid) begin
                if (rd_cnt < 64) rbuf[rd_cnt] <= rd_data;
                rd_cnt <= rd_cnt + 1;
                if (!got_rd) begin got_rd <= 1'b1; first_rd_cyc <= cyc; end
            end
            if (done) done_cnt <= done_cnt + 1;
            if (!ce_n) begin
                if (seen_low && hrun > 0 && hrun < min_gap) min_gap <= hrun;
                hrun <= 0; seen_low <= 1'b1;
                run <= run + 1;
                if (run + 1 > max_run) max_run <= run + 1;
            end else begin
                run <= 0;
                hrun <= hrun + 1;
            end
            prev_adv <= !adv_n;
            if (!adv_n) begin
                adv_cnt <= adv_cnt + 1;
                if (!got_adv) begin got_adv <= 1'b1; adv_cyc <= cyc; end
                if (prev_adv || ce_n || (we_n != !req_write)) bad_adv <= 1'b1;
            end
            if (!oe_n && (!we_n || lb_n || ub_n || dq_oe)) bad_rd <= 1'b1;
            if (!m_wait_n && (wr_pull || dut.mem_oe_n == 1'b0 && 1'b0)) bad_wait <= 1'b1;
            if (req_ready && !ce_n) bad_ready <= 1'b1;
        end
    end

    // ---------------- helpers ----------------
    task automatic check(input logic ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic run_op(input logic wr, input logic [19:0] a, input logic [15:0] n,
                          input logic [15:0] seed, input logic [1:0] be);
        @(posedge clk); #1;
        mon_clr = 1'b1; op_seed = seed; wr_be = be;
        req_valid = 1'b1; req_write = wr; req_addr = a; req_len = n;
        @(posedge clk); #1;
        mon_clr = 1'b0; req_valid = 1'b0;
        begin : wait_done
            for (int k = 0; k < 3000; k++) begin
                @(negedge clk);
                if (done) disable wait_done;
            end
            check(1'b0, "R10 timeout waiting for done", 0, 1);
        end
        @(posedge clk); @(negedge clk);
        for (int k = 0; k < 50 && !req_ready; k++) @(negedge clk);
        if (wr) begin
            for (int i = 0; i < n; i++) begin
                if (be[0]) shadow[(a + 20'(i)) & 20'h1FF][7:0]  = word_of(seed, i)[7:0];
                if (be[1]) shadow[(a + 20'(i)) & 20'h1FF][15:8] = word_of(seed, i)[15:8];
            end
        end
    endtask

    function automatic int data_errs(input logic [19:0] a, input int n);
        int e = 0;
        for (int i = 0; i < n; i++)
            if (rbuf[i] !== shadow[(a + 20'(i)) & 20'h1FF]) e++;
        return e;
    endfunction

    // ---------------- watchdog ----------------
    initial begin
        #(CLK_PERIOD * 150000);
        checks++; fails++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    // ---------------- main ----------------
    initial begin
        for (int i = 0; i < 512; i++) shadow[i] = 16'(i * 7 + 3);
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check(ce_n && adv_n && oe_n && we_n && req_ready && !rd_valid && !done,
              "R1 idle bus after reset", {ce_n, adv_n, oe_n, we_n, req_ready, rd_valid, done}, 7'b1111100);

        // vector table
        for (int v = 0; v < NVEC; v++) begin
            logic [19:0] a;
            logic [15:0] n;
            int          exp_adv;
            a = VEC[v][63:44]; n = VEC[v][43:28];
            inject = int'(VEC[v][27:24]); exp_adv = int'(VEC[v][23:20]);
            run_op(1'b1, a, n, VEC[v][15:0], 2'b11);
            check(adv_cnt == exp_adv, "R8 burst count for write", adv_cnt, exp_adv);
            check(max_run <= CE_LIM, "R8 chip enable low length", max_run, CE_LIM);
            check(!bad_adv, "R2 single address clock with write enable", bad_adv, 0);
            run_op(1'b0, a, n, 16'h0, 2'b11);
            check(rd_cnt == n && data_errs(a, n) == 0, "R5 read data in order",
                  data_errs(a, n), 0);
            check(!bad_wait && done_cnt == 1, "R4 no movement under wait / R10 single done",
                  done_cnt, 1);
            if (exp_adv > 1) check(min_gap >= GAP, "R9 chip enable high gap", min_gap, GAP);
            check(max_run <= CE_LIM && !bad_rd, "R7 read lanes and R8 length on read",
                  max_run, CE_LIM);
        end
        inject = 0;

        // R3 latency with normal wait
        run_op(1'b0, 20'h00010, 16'd4, 16'h0, 2'b11);
        check(first_rd_cyc - adv_cyc == LAT + 1, "R3 first read word timing",
              first_rd_cyc - adv_cyc, LAT + 1);
        // R3 latency kept when wait releases early
        early = 1'b1;
        run_op(1'b0, 20'h00010, 16'd4, 16'h0, 2'b11);
        check(first_rd_cyc - adv_cyc == LAT + 1, "R3 latency with early wait release",
              first_rd_cyc - adv_cyc, LAT + 1);
        check(data_errs(20'h00010, 4) == 0, "R3 data with early wait release",
              data_errs(20'h00010, 4), 0);
        early = 1'b0;

        // R6 byte enables
        run_op(1'b1, 20'h00040, 16'd2, 16'hAAAA, 2'b11);
        run_op(1'b1, 20'h00040, 16'd1, 16'h1234, 2'b01);
        run_op(1'b1, 20'h00041, 16'd1, 16'h5678, 2'b10);
        run_op(1'b0, 20'h00040, 16'd2, 16'h0, 2'b11);
        check(rbuf[0] == {word_of(16'hAAAA, 0)[15:8], 8'h34}, "R6 low byte only",
              int'(rbuf[0]), int'({word_of(16'hAAAA, 0)[15:8], 8'h34}));
        check(rbuf[1] == {8'h56, word_of(16'hAAAA, 1)[7:0]}, "R6 high byte only",
              int'(rbuf[1]), int'({8'h56, word_of(16'hAAAA, 1)[7:0]}));

        // R10 ready low during burst
        check(!bad_ready, "R10 ready only while idle", bad_ready, 0);

        // R11 zero length ignored
        @(posedge clk); #1;
        mon_clr = 1'b1; req_valid = 1'b1; req_write = 1'b1; req_addr = 20'h00080; req_len = 16'd0;
        @(posedge clk); #1;
        mon_clr = 1'b0; req_valid = 1'b0;
        repeat (10) @(negedge clk);
        check(adv_cnt == 0 && done_cnt == 0 && ce_n && req_ready,
              "R11 zero length ignored", adv_cnt + done_cnt, 0);
        run_op(1'b0, 20'h00080, 16'd1, 16'h0, 2'b11);
        check(rbuf[0] == shadow[9'h080], "R11 memory untouched", int'(rbuf[0]), int'(shadow[9'h080]));

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule